// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the integer execution slice of a small processor datapath. One operation code selects a bitwise operation (AND, OR, XOR, NOT, TEST) or an arithmetic one (ADD, ADC, SUB, SBB, INC, DEC, NEG). Two operands come in, and a width input chooses 8-bit or 16-bit arithmetic. The result and its write enable are produced combinationally. Six status flags (carry, overflow, zero, sign, parity, half-carry) are held in a register inside the block and update on a clock edge when the strobe is high.

Every operation has its own set of flags that it may touch. Bitwise operations clear carry, overflow and half-carry. NOT leaves all flags alone. INC and DEC keep carry untouched. TEST sets the flags but does not ask for its result to be written. ADC and SBB read the held carry, so a multi-word add or subtract is a chain: ADD or SUB on the low word, then ADC or SBB on each higher word.

Top module: `alu_flag_core`

## Requirements
- R1: While `rst` is high at a clock edge, all six flag outputs become 0 at that edge.
- R2: AND, OR and XOR put the bitwise result on `res_o`. On a strobed cycle they clear carry, overflow and half-carry, and they set zero, sign and parity from the result.
- R3: TEST computes the AND of the operands on `res_o` and sets the flags exactly as AND would. `res_we_o` stays 0.
- R4: NOT puts the bitwise inverse of `a_i` (within the selected width) on `res_o`, drives `res_we_o` high, and changes no flag.
- R5: For every flag-writing operation, zero is 1 when the result within the width is all zeros. Sign is the result's top bit within the width. Parity is 1 when bits 7..0 of the result hold an even number of ones.
- R6: ADD and SUB update all six flags. Carry is the carry out of the top bit; on SUB it is the borrow. Half-carry is the carry (borrow on SUB) out of bit 3. Overflow is set when the signed result is out of range. Examples: 8-bit 22h-44h = DEh with C=1 O=0 Z=0 S=1 P=1 A=1. 16-bit 5000h+5000h sets O and clears C. 16-bit FFFFh+FFFFh = FFFEh with C=1, O=0.
- R7: ADC adds the held carry to the sum. SBB subtracts the held carry as a borrow. Flags update as for ADD and SUB.
- R8: INC adds one to `a_i` and DEC subtracts one. Both update overflow, zero, sign, parity and half-carry and leave carry unchanged.
- R9: NEG returns 0 minus `a_i` in two's complement and updates flags as SUB from zero would. Carry is set exactly when the operand is nonzero.
- R10: With `wide_i`=0 only bits 7..0 of the operands are used. Bits 15..8 of `res_o` are 0, and carry, overflow and sign are taken at bit 7. With `wide_i`=1 all 16 bits are used.
- R11: Flags change only on an edge where `valid_i` is 1. Op codes Ch to Fh produce `res_o`=0 and `res_we_o`=0 and change no flag.
- R12: `res_we_o` is 1 exactly when `valid_i` is 1 and the code is a result-writing operation. Op codes are 0 AND, 1 OR, 2 XOR, 3 NOT, 4 TEST, 5 ADD, 6 ADC, 7 SUB, 8 SBB, 9 INC, Ah DEC, Bh NEG.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| valid_i | input | 1 | Strobe: operation is live, flags update at the edge |
| wide_i | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit |
| op_i | input | 4 | Operation code |
| a_i | input | 16 | First operand (destination operand) |
| b_i | input | 16 | Second operand |
| res_o | output | 16 | Operation result |
| res_we_o | output | 1 | Result should be written back |
| cf_o | output | 1 | Carry / borrow flag |
| of_o | output | 1 | Signed overflow flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| pf_o | output | 1 | Even-parity flag of the low byte |
| af_o | output | 1 | Half-carry / half-borrow flag |

## Verification
The hardest states to reach are those in which a flag must survive an operation that writes the others. Examples are a carry set by one addition that has to pass unchanged through an INC and then feed an ADC, and a zero flag that must outlast a NOT. The stimulus table is therefore one ordered sequence, not independent vectors. Each row is placed so that the flags left by the previous row differ from what a wrongly updating flag would produce. The narrow-width rows carry nonzero high bytes on purpose, so that any leak of bits 15..8 into the result or the flags is visible.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_AND  = 4'h0,
    OP_OR   = 4'h1,
    OP_XOR  = 4'h2,
    OP_NOT  = 4'h3,
    OP_TEST = 4'h4,
    OP_ADD  = 4'h5,
    OP_ADC  = 4'h6,
    OP_SUB  = 4'h7,
    OP_SBB  = 4'h8,
    OP_INC  = 4'h9,
    OP_DEC  = 4'hA,
    OP_NEG  = 4'hB
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic o;
    logic z;
    logic s;
    logic p;
    logic a;
  } alu_flags_t;
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] res,
  output logic          hit
);
  always_comb begin
    hit = 1'b1;
    res = '0;
    case (op)
      OP_AND, OP_TEST: res = a & b;
      OP_OR:           res = a | b;
      OP_XOR:          res = a ^ b;
      OP_NOT:          res = ~a & mask;
      default:         hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
  import alu_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic [3:0]    op,
  input  logic          wide,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] mask,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          carry,
  output logic          ovf,
  output logic          aux,
  output logic          hit
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic          sub;
  logic          cflag_in;
  logic [DW-1:0] x, y, yi;
  logic          ci;
  logic [DW:0]   sum;
  logic [4:0]    nib;
  logic          cout, sx, sy, sr;

  always_comb begin
    hit      = 1'b1;
    sub      = 1'b0;
    cflag_in = 1'b0;
    x        = a;
    y        = b;
    case (op)
      OP_ADD: ;
      OP_ADC: cflag_in = cin;
      OP_SUB: sub = 1'b1;
      OP_SBB: begin sub = 1'b1; cflag_in = cin; end
      OP_INC: y = ONE;
      OP_DEC: begin y = ONE; sub = 1'b1; end
      OP_NEG: begin x = '0; y = a; sub = 1'b1; end
      default: hit = 1'b0;
    endcase
  end

  // Subtraction is x + ~y + ~borrow within the selected width
  assign yi  = sub ? (~y & mask) : y;
  assign ci  = sub ? ~cflag_in : cflag_in;
  assign sum = {1'b0, x} + {1'b0, yi} + {{DW{1'b0}}, ci};
  assign nib = {1'b0, x[3:0]} + {1'b0, yi[3:0]} + {4'b0, ci};
  assign res = sum[DW-1:0] & mask;

  assign cout  = wide ? sum[DW] : sum[NW];
  assign carry = sub ? ~cout : cout;
  assign aux   = sub ? ~nib[4] : nib[4];

  assign sx  = wide ? x[DW-1]   : x[NW-1];
  assign sy  = wide ? yi[DW-1]  : yi[NW-1];
  assign sr  = wide ? res[DW-1] : res[NW-1];
  assign ovf = (sx == sy) && (sr != sx);
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  alu_flags_t en,
  input  alu_flags_t nxt,
  output alu_flags_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      if (en.c) q.c <= nxt.c;
      if (en.o) q.o <= nxt.o;
      if (en.z) q.z <= nxt.z;
      if (en.s) q.s <= nxt.s;
      if (en.p) q.p <= nxt.p;
      if (en.a) q.a <= nxt.a;
    end
  end

  // R1: reset clears every flag
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (q == '0));
endmodule

// File: rtl/alu_flag_core.sv
module alu_flag_core
  import alu_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic          wide_i,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o,
  output logic          res_we_o,
  output logic          cf_o,
  output logic          of_o,
  output logic          zf_o,
  output logic          sf_o,
  output logic          pf_o,
  output logic          af_o
);
  localparam logic [DW-1:0] NARROW_MASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};

  logic [DW-1:0] mask, a_m, b_m;
  logic [DW-1:0] lres, ares, res_c;
  logic          lhit, ahit;
  logic          acarry, aovf, aaux;
  alu_flags_t    fq, fnxt, fen;

  assign mask = wide_i ? '1 : NARROW_MASK;
  assign a_m  = a_i & mask;
  assign b_m  = b_i & mask;

  alu_logic_unit #(.DW(DW)) u_logic (
    .op(op_i), .a(a_m), .b(b_m), .mask(mask), .res(lres), .hit(lhit)
  );

  alu_arith_unit #(.DW(DW), .NW(NW)) u_arith (
    .op(op_i), .wide(wide_i), .a(a_m), .b(b_m), .mask(mask), .cin(fq.c),
    .res(ares), .carry(acarry), .ovf(aovf), .aux(aaux), .hit(ahit)
  );

  assign res_c = lhit ? lres : (ahit ? ares : '0);

  always_comb begin
    fnxt.z = (res_c == '0);
    fnxt.s = wide_i ? res_c[DW-1] : res_c[NW-1];
    fnxt.p = ~^res_c[7:0];
    fnxt.c = lhit ? 1'b0 : acarry;
    fnxt.o = lhit ? 1'b0 : aovf;
    fnxt.a = lhit ? 1'b0 : aaux;
    fen    = '0;
    if (valid_i) begin
      case (op_i)
        OP_AND, OP_OR, OP_XOR, OP_TEST,
        OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG: fen = '1;
        OP_INC, OP_DEC: begin fen = '1; fen.c = 1'b0; end
        default: fen = '0;
      endcase
    end
  end

  alu_flag_reg u_flags (.clk(clk), .rst(rst), .en(fen), .nxt(fnxt), .q(fq));

  assign res_o    = res_c;
  assign res_we_o = valid_i && (lhit || ahit) && (op_i != OP_TEST);
  assign cf_o = fq.c;
  assign of_o = fq.o;
  assign zf_o = fq.z;
  assign sf_o = fq.s;
  assign pf_o = fq.p;
  assign af_o = fq.a;

  // R2: bitwise operations leave carry, overflow and half-carry clear
  a_r2_logic_clears: assert property (@(posedge clk) disable iff (rst)
    valid_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR || op_i == OP_TEST)
    |=> (!cf_o && !of_o && !af_o));

  // R4: NOT touches no flag
  a_r4_not_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    valid_i && op_i == OP_NOT |=> $stable({cf_o, of_o, zf_o, sf_o, pf_o, af_o}));

  // R5: zero and parity track the presented result
  a_r5_zero_parity: assert property (@(posedge clk) disable iff (rst)
    valid_i && op_i <= OP_NEG && op_i != OP_NOT
    |=> (zf_o == ($past(res_o) == '0)) && (pf_o == ~^$past(res_o[7:0])));

  // R8: INC and DEC keep the carry
  a_r8_incdec_keep_carry: assert property (@(posedge clk) disable iff (rst)
    valid_i && (op_i == OP_INC || op_i == OP_DEC) |=> (cf_o == $past(cf_o)));

  // R10: narrow mode never drives the high byte
  a_r10_narrow_upper: assert property (@(posedge clk) disable iff (rst)
    !wide_i |-> (res_o[DW-1:NW] == '0));

  // R11: no strobe, no flag change
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable({cf_o, of_o, zf_o, sf_o, pf_o, af_o}));
endmodule

// File: tb/sim_alu_flag_core.sv
module sim_alu_flag_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [3:0]  op_i = 4'h0;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic [15:0] res_o;
  logic        res_we_o;
  logic        cf_o, of_o, zf_o, sf_o, pf_o, af_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu_flag_core u0 (
    .clk(clk), .rst(rst), .valid_i(valid_i), .wide_i(wide_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .res_o(res_o), .res_we_o(res_we_o),
    .cf_o(cf_o), .of_o(of_o), .zf_o(zf_o), .sf_o(sf_o), .pf_o(pf_o), .af_o(af_o)
  );

  // Row: wide, op, a, b, expected result, expected write enable, flags {C,O,Z,S,P,A} after the edge
  localparam int NV = 20;
  localparam logic [59:0] VEC [0:NV-1] = '{
    {1'b0, 4'h7, 16'h0022, 16'h0044, 16'h00DE, 1'b1, 6'b100111},
    {1'b1, 4'h5, 16'h5000, 16'h5000, 16'hA000, 1'b1, 6'b010110},
    {1'b1, 4'h5, 16'hFFFF, 16'hFFFF, 16'hFFFE, 1'b1, 6'b100101},
    {1'b0, 4'h9, 16'h007F, 16'h0000, 16'h0080, 1'b1, 6'b110101},
    {1'b1, 4'h6, 16'h0001, 16'h0002, 16'h0004, 1'b1, 6'b000000},
    {1'b0, 4'hA, 16'h0000, 16'h0000, 16'h00FF, 1'b1, 6'b000111},
    {1'b0, 4'h7, 16'h0000, 16'h0001, 16'h00FF, 1'b1, 6'b100111},
    {1'b0, 4'h8, 16'h0005, 16'h0002, 16'h0002, 1'b1, 6'b000000},
    {1'b0, 4'h0, 16'h00F0, 16'h000F, 16'h0000, 1'b1, 6'b001010},
    {1'b0, 4'h3, 16'h770F, 16'h0000, 16'h00F0, 1'b1, 6'b001010},
    {1'b1, 4'h1, 16'h8000, 16'h0001, 16'h8001, 1'b1, 6'b000100},
    {1'b1, 4'h4, 16'h1234, 16'h00FF, 16'h0034, 1'b0, 6'b000000},
    {1'b1, 4'h2, 16'hAAAA, 16'h5555, 16'hFFFF, 1'b1, 6'b000110},
    {1'b1, 4'hB, 16'h0001, 16'h0000, 16'hFFFF, 1'b1, 6'b100111},
    {1'b0, 4'hB, 16'h0080, 16'h0000, 16'h0080, 1'b1, 6'b110100},
    {1'b0, 4'hB, 16'h0000, 16'h0000, 16'h0000, 1'b1, 6'b001010},
    {1'b0, 4'h5, 16'hAB80, 16'hCD80, 16'h0000, 1'b1, 6'b111010},
    {1'b0, 4'hF, 16'h0012, 16'h0034, 16'h0000, 1'b0, 6'b111010},
    {1'b0, 4'h5, 16'h007F, 16'h0001, 16'h0080, 1'b1, 6'b010101},
    {1'b1, 4'h8, 16'h0000, 16'h0000, 16'h0000, 1'b1, 6'b001010}
  };

  function automatic string req_of(input logic [3:0] op, input logic w);
    case (op)
      4'h0, 4'h1, 4'h2:  return w ? "R2" : "R2/R10";
      4'h3:              return "R4";
      4'h4:              return "R3";
      4'h5, 4'h7:        return w ? "R6" : "R6/R10";
      4'h6, 4'h8:        return "R7";
      4'h9, 4'hA:        return "R8";
      4'hB:              return "R9";
      default:           return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] flags();
    return {cf_o, of_o, zf_o, sf_o, pf_o, af_o};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", {26'b0, flags()}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [59:0] v;
      v = VEC[i];
      @(negedge clk);
      valid_i = 1'b1;
      wide_i  = v[59];
      op_i    = v[58:55];
      a_i     = v[54:39];
      b_i     = v[38:23];
      #1;
      check({req_of(v[58:55], v[59]), " result"}, {16'b0, res_o}, {16'b0, v[22:7]});
      check("R12 write enable", {31'b0, res_we_o}, {31'b0, v[6]});
      @(negedge clk);
      check({req_of(v[58:55], v[59]), "/R5 flags"}, {26'b0, flags()}, {26'b0, v[5:0]});
      valid_i = 1'b0;
    end

    // R11: operation presented without strobe leaves flags alone (would give C,Z,A set)
    @(negedge clk);
    valid_i = 1'b0; wide_i = 1'b1; op_i = 4'h5; a_i = 16'hFFFF; b_i = 16'h0001;
    #1;
    check("R12 no strobe no write", {31'b0, res_we_o}, 32'h0);
    @(negedge clk);
    check("R11 idle flags held", {26'b0, flags()}, {26'b0, 6'b001010});

    // R1: reset in mid-run clears nonzero flags
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", {26'b0, flags()}, 32'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule